// File: doc/BRIEF.md
# BPSK Load-Modulation Transmit Bridge

This block sits between a self-timed processor and the load-modulation switch of a contact-less card front end. The processor writes one byte at a time over a four-phase bundled-data handshake. The bridge stores the byte in a single-entry holding register and then sends it as an asynchronous serial character. The character has a start bit, eight data bits and a stop bit, and each bit lasts one period of the subcarrier.

The serial level never leaves the chip directly. It sets the phase of a square-wave subcarrier, and that subcarrier drives the modulation switch. A one keeps the subcarrier at its reference phase. A zero inverts it. The link is half-duplex. While the processor holds the receive-mode input high, no new byte is accepted and no new character starts. A character already on the line still runs to its stop bit.

The subcarrier comes from a divide-by-`DIV` counter on the block clock, so one bit lasts `DIV` clock cycles. The last phase of the handshake (acknowledge falling) is held back until the holding register has been emptied. This throttles a processor that writes faster than the line can send.

Top module: `bpsk_tx_bridge`

## Requirements
- R1: While `rst_n` is low, `host_ack` is 0, `tx_line` is 1 and the subcarrier divider is cleared to count 0, so `lm_drive` is 0.
- R2: The divider counts 0 to `DIV-1` and wraps, advancing once per clock after reset. The reference subcarrier is 0 for counts below `DIV/2` and 1 otherwise. `lm_drive` equals the reference while `tx_line` is 1 and its inverse while `tx_line` is 0.
- R3: `host_req` and `rx_mode` each pass through a two-flop synchronizer. With the holding register empty, the state machine leaves `HS_IDLE` and moves to `HS_ACK` on the first clock where the synchronized request is high and synchronized receive mode is low. On that clock it captures `host_data` and raises `host_ack`. In a quiet system `host_ack` is seen high three clock edges after `host_req` rises.
- R4: After the request falls, `HS_ACK` moves to `HS_HOLD`. `host_ack` stays high until the byte has been moved from the holding register into the shifter. Only then does `HS_HOLD` return to `HS_IDLE` and drop `host_ack`. By that time the start bit is already on `tx_line`.
- R5: The framer runs `FR_IDLE` → `FR_START` → `FR_DATA` → `FR_STOP`. It changes `tx_line` only on the clock where the divider wraps to 0. The character is a start bit of 0, then the eight data bits least significant first, then a stop bit of 1. Each bit lasts `DIV` clocks.
- R6: With no byte pending, the framer stays in `FR_IDLE` and `tx_line` is 1.
- R7: A byte captured while a character is being sent starts straight from `FR_STOP` into `FR_START`. The next start bit begins ten bit periods after the previous one, with no idle bit between them.
- R8: While synchronized `rx_mode` is high, no request is acknowledged and no new character starts. The request is served once `rx_mode` returns low.
- R9: If `rx_mode` rises during a character, that character is completed through its stop bit. A request made afterwards stays unacknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the subcarrier is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_mode | input | 1 | Half-duplex direction from the processor; high blocks transmission |
| host_req | input | 1 | Four-phase write request from the processor |
| host_data | input | DATA_W | Bundled write data, stable while `host_req` is high |
| host_ack | output | 1 | Four-phase write acknowledge |
| tx_line | output | 1 | Framed serial level (NRZ) before modulation |
| lm_drive | output | 1 | BPSK subcarrier driving the load-modulation switch |

## Verification
The hardest situation to reach is a receive-mode change that lands inside a character while another write is waiting. The stimulus handles it in steps. It waits at the ports for the start bit of one character and lets a few bit periods pass. It then raises `rx_mode`, allows for the synchronizer delay, and raises a fresh request. This shows the character finishing with no acknowledge to the later request. Back-to-back framing is reached by issuing the second write as soon as the first acknowledge drops, so that the byte lands in the holding register while the shifter is busy. The gap between the two start bits is then measured in bit periods.

// File: rtl/bpsk_tx_bridge_pkg.sv
package bpsk_tx_bridge_pkg;

    // handshake controller states
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_ACK  = 2'd1,
        HS_HOLD = 2'd2
    } hs_state_t;

    // framing states
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } fr_state_t;

endpackage

// File: rtl/bpsk_tx_bridge_sync.sv
module bpsk_tx_bridge_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/bpsk_tx_bridge_hs.sv
module bpsk_tx_bridge_hs
    import bpsk_tx_bridge_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_s,
    input  logic              ren_s,
    input  logic [DATA_W-1:0] host_data,
    input  logic              take,
    output logic              host_ack,
    output logic              buf_full,
    output logic [DATA_W-1:0] buf_data
);

    hs_state_t st_q, st_d;
    logic      capture;

    assign capture = (st_q == HS_IDLE) && req_s && !ren_s && !buf_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= HS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_IDLE: if (capture)   st_d = HS_ACK;
            HS_ACK:  if (!req_s)    st_d = HS_HOLD;
            HS_HOLD: if (!buf_full) st_d = HS_IDLE;
            default:                st_d = HS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            HS_ACK, HS_HOLD: host_ack = 1'b1;
            default:         host_ack = 1'b0;
        endcase
    end

    // one-byte holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_data <= '0;
        end else if (capture) begin
            buf_full <= 1'b1;
            buf_data <= host_data;
        end else if (take) begin
            buf_full <= 1'b0;
        end
    end

endmodule

// File: rtl/bpsk_tx_bridge_framer.sv
module bpsk_tx_bridge_framer
    import bpsk_tx_bridge_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              ren_s,
    output logic              take,
    output logic              tx_line,
    output logic              lm_drive
);

    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam int HALF  = DIV / 2;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    fr_state_t         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;
    logic              line_q;
    logic              tick;
    logic              sub_ref;

    // subcarrier divider
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick    = (cnt_q == CNT_LAST);
    assign sub_ref = (cnt_q >= CNT_HALF);
    assign take    = tick && buf_full && !ren_s &&
                     ((st_q == FR_IDLE) || (st_q == FR_STOP));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions, taken at bit boundaries only
    always_comb begin
        st_d = st_q;
        if (tick) begin
            unique case (st_q)
                FR_IDLE:  if (take) st_d = FR_START;
                FR_START: st_d = FR_DATA;
                FR_DATA:  if (idx_q == IDX_LAST) st_d = FR_STOP;
                FR_STOP:  st_d = take ? FR_START : FR_IDLE;
                default:  st_d = FR_IDLE;
            endcase
        end
    end

    // outputs: shifter, bit index and line level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            idx_q  <= '0;
            line_q <= 1'b1;
        end else if (tick) begin
            unique case (st_q)
                FR_IDLE, FR_STOP: begin
                    if (take) begin
                        sh_q   <= buf_data;
                        line_q <= 1'b0;
                    end else begin
                        line_q <= 1'b1;
                    end
                end
                FR_START: begin
                    line_q <= sh_q[0];
                    sh_q   <= sh_q >> 1;
                    idx_q  <= '0;
                end
                FR_DATA: begin
                    if (idx_q == IDX_LAST) begin
                        line_q <= 1'b1;
                    end else begin
                        line_q <= sh_q[0];
                        sh_q   <= sh_q >> 1;
                        idx_q  <= idx_q + 1'b1;
                    end
                end
                default: line_q <= 1'b1;
            endcase
        end
    end

    assign tx_line  = line_q;
    assign lm_drive = sub_ref ^ ~line_q;

endmodule

// File: rtl/bpsk_tx_bridge.sv
module bpsk_tx_bridge #(
    parameter int DATA_W      = 8,
    parameter int DIV         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_mode,
    input  logic              host_req,
    input  logic [DATA_W-1:0] host_data,
    output logic              host_ack,
    output logic              tx_line,
    output logic              lm_drive
);

    logic [1:0]        sync_q;
    logic              req_s;
    logic              ren_s;
    logic              take;
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;

    bpsk_tx_bridge_sync #(
        .STAGES (SYNC_STAGES),
        .W      (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rx_mode, host_req}),
        .q     (sync_q)
    );

    assign req_s = sync_q[0];
    assign ren_s = sync_q[1];

    bpsk_tx_bridge_hs #(
        .DATA_W (DATA_W)
    ) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_s     (req_s),
        .ren_s     (ren_s),
        .host_data (host_data),
        .take      (take),
        .host_ack  (host_ack),
        .buf_full  (buf_full),
        .buf_data  (buf_data)
    );

    bpsk_tx_bridge_framer #(
        .DATA_W (DATA_W),
        .DIV    (DIV)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_full (buf_full),
        .buf_data (buf_data),
        .ren_s    (ren_s),
        .take     (take),
        .tx_line  (tx_line),
        .lm_drive (lm_drive)
    );

endmodule

// File: rtl/bpsk_tx_bridge_chk.sv
module bpsk_tx_bridge_chk #(
    parameter int DIV = 16
) (
    input logic clk,
    input logic rst_n,
    input logic host_ack,
    input logic tx_line,
    input logic lm_drive,
    input logic req_s,
    input logic ren_s,
    input logic buf_full
);

    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] C_LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] C_HALF = CW'(DIV / 2);

    // independent model of the divider phase
    logic [CW-1:0] m_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              m_cnt <= '0;
        else if (m_cnt == C_LAST) m_cnt <= '0;
        else                     m_cnt <= m_cnt + 1'b1;
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!host_ack && tx_line));

    // R2
    a_r2_bpsk_phase: assert property (@(posedge clk) disable iff (!rst_n)
        lm_drive == ((m_cnt >= C_HALF) ^ !tx_line));

    // R3
    a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack) |-> ($past(req_s) && !$past(ren_s)));

    // R4
    a_r4_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && buf_full) |=> host_ack);

    // R5
    a_r5_bit_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_line) |-> (m_cnt == '0));

    // R8
    a_r8_no_accept_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_s && !host_ack) |=> !host_ack);

endmodule

bind bpsk_tx_bridge bpsk_tx_bridge_chk #(.DIV(DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_ack (host_ack),
    .tx_line  (tx_line),
    .lm_drive (lm_drive),
    .req_s    (req_s),
    .ren_s    (ren_s),
    .buf_full (buf_full)
);

// File: tb/bpsk_tx_bridge_tb.sv
module bpsk_tx_bridge_tb;

    localparam int DIV  = 16;
    localparam int HALF = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_mode = 1'b0;
    logic       host_req = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       host_ack;
    logic       tx_line;
    logic       lm_drive;

    always #4 clk = ~clk;

    bpsk_tx_bridge #(.DATA_W(8), .DIV(DIV), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_mode   (rx_mode),
        .host_req  (host_req),
        .host_data (host_data),
        .host_ack  (host_ack),
        .tx_line   (tx_line),
        .lm_drive  (lm_drive)
    );

    int         checks = 0;
    int         fails = 0;
    int         bcnt = 0;
    int         frames = 0;
    int         bit_no = 0;
    int         last_start = 0;
    int         last_gap = 0;
    int         mstate = 0;
    int         nb = 0;
    bit         done = 1'b0;
    logic [7:0] mbyte = 8'h00;
    logic [7:0] exp_q[$];

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // model of the subcarrier phase from R2
    always @(posedge clk) begin
        if (!rst_n)              bcnt <= 0;
        else if (bcnt == DIV-1)  bcnt <= 0;
        else                     bcnt <= bcnt + 1;
    end

    // monitor: R2 every cycle, frames sampled mid-bit and scored
    always @(negedge clk) begin
        int exp_lm;
        logic [7:0] e;
        if (rst_n) begin
            exp_lm = ((bcnt >= HALF) ? 1 : 0) ^ (tx_line ? 0 : 1);
            check(lm_drive == exp_lm[0], "R2 bpsk phase", int'(lm_drive), exp_lm);
            if (bcnt == HALF) begin
                bit_no++;
                case (mstate)
                    0: if (!tx_line) begin
                        last_gap   = bit_no - last_start;
                        last_start = bit_no;
                        nb         = 0;
                        mstate     = 1;
                    end
                    1: begin
                        mbyte[nb] = tx_line;
                        nb++;
                        if (nb == 8) mstate = 2;
                    end
                    default: begin
                        check(tx_line == 1'b1, "R5 stop bit", int'(tx_line), 1);
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R5 unexpected frame", int'(mbyte), 0);
                        end else begin
                            e = exp_q.pop_front();
                            check(mbyte == e, "R3 R5 frame data", int'(mbyte), int'(e));
                        end
                        frames++;
                        mstate = 0;
                    end
                endcase
            end
        end
    end

    task automatic send(input logic [7:0] b, input bit fast);
        int n;
        while (host_ack) @(negedge clk);
        host_data = b;
        host_req  = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!host_ack);
        if (fast) check(n == 3, "R3 ack latency", n, 3);
        exp_q.push_back(b);
        host_req = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        while (frames < n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", frames, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ok;
        bit saw_ack;
        bit saw_tx;
        int base;

        // R1 reset state
        repeat (5) @(negedge clk);
        check(host_ack == 1'b0, "R1 ack in reset", int'(host_ack), 0);
        check(tx_line == 1'b1, "R1 line in reset", int'(tx_line), 1);
        check(lm_drive == 1'b0, "R1 modulator in reset", int'(lm_drive), 0);
        rst_n = 1'b1;

        // R6 idle line
        ok = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (!tx_line) ok = 1'b0;
        end
        check(ok, "R6 idle line high", int'(ok), 1);

        // R4 ack held until byte leaves the buffer
        send(8'hA5, 1'b1);
        while (host_ack) @(negedge clk);
        check(tx_line == 1'b0, "R4 ack dropped only with start bit on line", int'(tx_line), 0);
        wait_frames(1);

        // R5 several data patterns
        send(8'h00, 1'b1); wait_frames(2);
        send(8'hFF, 1'b1); wait_frames(3);
        send(8'h01, 1'b1); wait_frames(4);
        send(8'h80, 1'b1); wait_frames(5);
        send(8'h3C, 1'b1); wait_frames(6);

        // R7 back-to-back characters
        send(8'h5A, 1'b1);
        send(8'hC3, 1'b1);
        wait_frames(8);
        check(last_gap == 10, "R7 start-to-start bit periods", last_gap, 10);

        // R8 receive mode blocks acceptance and transmission
        rx_mode = 1'b1;
        repeat (5) @(negedge clk);
        host_data = 8'h69;
        host_req  = 1'b1;
        saw_ack = 1'b0;
        saw_tx  = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (host_ack) saw_ack = 1'b1;
            if (!tx_line) saw_tx = 1'b1;
        end
        check(!saw_ack, "R8 no ack in receive mode", int'(saw_ack), 0);
        check(!saw_tx, "R8 no frame in receive mode", int'(saw_tx), 0);
        rx_mode = 1'b0;
        while (!host_ack) @(negedge clk);
        exp_q.push_back(8'h69);
        host_req = 1'b0;
        wait_frames(9);

        // R9 receive mode raised mid-frame
        base = frames;
        send(8'h96, 1'b1);
        while (tx_line) @(negedge clk);
        repeat (40) @(negedge clk);
        rx_mode = 1'b1;
        repeat (5) @(negedge clk);
        host_data = 8'h11;
        host_req  = 1'b1;
        wait_frames(base + 1);
        check(host_ack == 1'b0, "R9 later request not accepted", int'(host_ack), 0);
        saw_tx = 1'b0;
        repeat (100) begin
            @(negedge clk);
            if (!tx_line) saw_tx = 1'b1;
        end
        check(!saw_tx, "R9 no new frame after completion", int'(saw_tx), 0);
        check(frames == base + 1, "R9 frame completed", frames, base + 1);
        rx_mode = 1'b0;
        while (!host_ack) @(negedge clk);
        exp_q.push_back(8'h11);
        host_req = 1'b0;
        wait_frames(base + 2);

        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R5 all frames delivered", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule